// File: doc/BRIEF.md
# Audio Port Bring-Up Sequencer

This block runs the start and stop sequences of one direction (transmit or receive) of a serial audio port. The port's control register holds five reset/enable bits for that direction. When they are set in the wrong order, or before the previous one has taken effect, the port comes up with garbage in its shift registers or a frame sync that is out of step. The sequencer takes this work off software. On a start request it sets the five bits one at a time in a fixed order. It reads the register back and does not go on until each bit shows as set. It primes the data buffer with a zero word at the right point and, on the transmit side, waits for the serializer to report that it is ready.

A stop request clears the whole control group and clears the status register. The sequencer owns an optional FIFO enable. The FIFO is switched on before the first control write of a start and switched off before the clearing write of a stop. If a readback check or the ready wait exceeds its limit, the sequence halts. The bits already released stay as they are, and a sticky error is raised that only a stop removes.

The control interface is plain: single-cycle write strobes with a full register word, a continuously valid readback word, and level-sensitive ready inputs. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `aport_bringup_seq`

## Requirements
- R1: During and after reset, `busy`, `err`, `fifo_en`, `ctl_wr_en`, `buf_wr` and `stat_clr` are all low.
- R2: A start issues exactly five control writes, and each write adds one bit to the previous word. The group sits at register bits 8..12 on the transmit path and bits 0..4 on the receive path. Within the group, bit 0 is the bit-clock divider, bit 1 the high-frequency divider, bit 2 the serializer clear, bit 3 the state machine and bit 4 the frame sync. They are released in the order 1, 0, 2, 3, 4, so the transmit words are 0x0200, 0x0300, 0x0700, 0x0F00 and 0x1F00. No write touches a bit outside the group.
- R3: The next control write is issued only after `ctl_rd_data` shows the bit just written as set. If the bit has not appeared after RETRY_MAX consecutive readback cycles, `err` rises exactly RETRY_MAX cycles after that write is seen and the sequence halts with the released bits left set.
- R4: Exactly one `buf_wr` pulse (a zero-word write) occurs after the serializer-clear write and before the state-machine write.
- R5: On the transmit path, once the frame-sync bit is confirmed, the block waits for `ser_ready` of the lowest-indexed serializer whose `ser_is_tx` bit is 1 (serializer 0 if none is). The ready inputs of all other serializers are ignored. When the selected serializer is ready, a second `buf_wr` pulse is issued and `busy` falls in the same cycle.
- R6: If the selected serializer is not ready within READY_MAX cycles, `err` rises, `busy` falls and no second `buf_wr` is issued.
- R7: `fifo_en` takes the value of `use_fifo` in the cycle after an accepted start, before the first control write. On a stop it falls in the cycle after the stop, one cycle before the clearing write.
- R8: `busy` rises in the cycle after an accepted start and stays high until the sequence completes or errors. A start while `busy` or `err` is high is ignored.
- R9: One cycle after `stop`, `busy` and `err` are low. Two cycles after `stop`, a control write of all zeros and a `stat_clr` pulse (the status register written with all ones) appear together.
- R10: Once set, `err` holds until a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request pulse |
| stop | input | 1 | Stop request; takes priority over start |
| use_fifo | input | 1 | FIFO in use for this direction |
| ser_is_tx | input | NSER | Serializer configured as transmitter, one bit each |
| ser_ready | input | NSER | Serializer ready status, one bit each |
| ctl_rd_data | input | CTL_W | Readback of the control register |
| ctl_wr_en | output | 1 | Control register write strobe |
| ctl_wr_data | output | CTL_W | Word written to the control register |
| buf_wr | output | 1 | Zero-word write to the data buffer |
| stat_clr | output | 1 | All-ones write to the status register |
| fifo_en | output | 1 | FIFO enable |
| busy | output | 1 | Start sequence in progress |
| err | output | 1 | Sticky timeout error |

## Verification
All outputs are registered. `busy` and `fifo_en` are due one cycle after the start edge, and the first control write follows one cycle later. Each later write comes two cycles after its predecessor's bit appears in the readback. The bench therefore logs every strobe with its cycle number at the falling edge and checks order and relative spacing, not absolute times, while randomising the readback latency of its register stub. For stop and the retry timeout the cycle is fixed, and the bench checks exactly one and two cycles after `stop` and exactly RETRY_MAX cycles after the stuck write. For the ready wait it checks that the second buffer write comes strictly after the selected ready and within a few cycles of the READY_MAX limit.

// File: rtl/aport_pkg.sv
package aport_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SET, ST_WAIT, ST_PRIME, ST_RDY, ST_PRIME2, ST_CLR
  } seq_state_t;

  localparam int unsigned GRP_BITS  = 5;
  localparam int unsigned STEP_W    = 3;
  // bit positions inside the control group
  localparam int unsigned B_BCLK    = 0;
  localparam int unsigned B_HCLK    = 1;
  localparam int unsigned B_SCLR    = 2;
  localparam int unsigned B_SMACH   = 3;
  localparam int unsigned B_FSYNC   = 4;
  // step indices that trigger extra actions
  localparam logic [STEP_W-1:0] STEP_SCLR = 3'd2;
  localparam logic [STEP_W-1:0] STEP_LAST = 3'd4;

  // release order: high-freq divider, bit clock, serializer clear, state machine, frame sync
  function automatic logic [2:0] step_to_bit(input logic [STEP_W-1:0] step);
    case (step)
      3'd0:    step_to_bit = 3'(B_HCLK);
      3'd1:    step_to_bit = 3'(B_BCLK);
      3'd2:    step_to_bit = 3'(B_SCLR);
      3'd3:    step_to_bit = 3'(B_SMACH);
      default: step_to_bit = 3'(B_FSYNC);
    endcase
  endfunction
endpackage

// File: rtl/aport_tmo_cnt.sv
module aport_tmo_cnt #(
  parameter int unsigned LIMIT = 1000
)(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic hit
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign hit = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (en && !hit) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/aport_first_tx.sv
module aport_first_tx #(
  parameter int unsigned NSER = 16
)(
  input  logic [NSER-1:0] ser_is_tx,
  input  logic [NSER-1:0] ser_ready,
  output logic            sel_ready
);
  localparam int unsigned IW = (NSER > 1) ? $clog2(NSER) : 1;

  logic [IW-1:0] sel;
  logic          found;

  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < NSER; i++) begin
      if (ser_is_tx[i] && !found) begin
        sel   = IW'(i);
        found = 1'b1;
      end
    end
  end

  assign sel_ready = ser_ready[sel];
endmodule

// File: rtl/aport_bringup_seq.sv
module aport_bringup_seq
  import aport_pkg::*;
#(
  parameter int unsigned CTL_W     = 16,
  parameter bit          TX_PATH   = 1'b1,
  parameter int unsigned NSER      = 16,
  parameter int unsigned RETRY_MAX = 1000,
  parameter int unsigned READY_MAX = 100000
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             use_fifo,
  input  logic [NSER-1:0]  ser_is_tx,
  input  logic [NSER-1:0]  ser_ready,
  input  logic [CTL_W-1:0] ctl_rd_data,
  output logic             ctl_wr_en,
  output logic [CTL_W-1:0] ctl_wr_data,
  output logic             buf_wr,
  output logic             stat_clr,
  output logic             fifo_en,
  output logic             busy,
  output logic             err
);
  localparam int unsigned GRP_LSB = TX_PATH ? 8 : 0;

  seq_state_t          state;
  logic [STEP_W-1:0]   step;
  logic [GRP_BITS-1:0] shadow, cur_mask;
  logic [CTL_W-1:0]    cur_word, wr_word;
  logic                seen, retry_hit, ready_hit, sel_ready;

  assign cur_mask = GRP_BITS'(1) << step_to_bit(step);
  assign cur_word = CTL_W'(cur_mask) << GRP_LSB;
  assign wr_word  = CTL_W'(shadow | cur_mask) << GRP_LSB;
  assign seen     = |(ctl_rd_data & cur_word);

  aport_tmo_cnt #(.LIMIT(RETRY_MAX)) u_retry (
    .clk(clk), .rst_n(rst_n),
    .clr(state != ST_WAIT),
    .en(state == ST_WAIT && !seen),
    .hit(retry_hit)
  );

  aport_tmo_cnt #(.LIMIT(READY_MAX)) u_ready (
    .clk(clk), .rst_n(rst_n),
    .clr(state != ST_RDY),
    .en(state == ST_RDY && !sel_ready),
    .hit(ready_hit)
  );

  generate
    if (TX_PATH) begin : g_tx
      aport_first_tx #(.NSER(NSER)) u_sel (
        .ser_is_tx(ser_is_tx), .ser_ready(ser_ready), .sel_ready(sel_ready)
      );
    end else begin : g_rx
      assign sel_ready = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      step        <= '0;
      shadow      <= '0;
      ctl_wr_en   <= 1'b0;
      ctl_wr_data <= '0;
      buf_wr      <= 1'b0;
      stat_clr    <= 1'b0;
      fifo_en     <= 1'b0;
      busy        <= 1'b0;
      err         <= 1'b0;
    end else begin
      ctl_wr_en <= 1'b0;
      buf_wr    <= 1'b0;
      stat_clr  <= 1'b0;
      // clearing write runs even when stop is still held
      if (state == ST_CLR) begin
        ctl_wr_en   <= 1'b1;
        ctl_wr_data <= '0;
        stat_clr    <= 1'b1;
        shadow      <= '0;
      end
      if (stop) begin
        fifo_en <= 1'b0;
        busy    <= 1'b0;
        err     <= 1'b0;
        state   <= ST_CLR;
      end else begin
        case (state)
          ST_IDLE: if (start && !err) begin
            busy    <= 1'b1;
            fifo_en <= use_fifo;
            step    <= '0;
            shadow  <= '0;
            state   <= ST_SET;
          end
          ST_SET: begin
            ctl_wr_en   <= 1'b1;
            ctl_wr_data <= wr_word;
            shadow      <= shadow | cur_mask;
            state       <= ST_WAIT;
          end
          ST_WAIT: begin
            if (seen) begin
              if (step == STEP_SCLR) state <= ST_PRIME;
              else if (step == STEP_LAST) begin
                if (TX_PATH) state <= ST_RDY;
                else begin
                  busy  <= 1'b0;
                  state <= ST_IDLE;
                end
              end else begin
                step  <= step + 1'b1;
                state <= ST_SET;
              end
            end else if (retry_hit) begin
              err   <= 1'b1;
              busy  <= 1'b0;
              state <= ST_IDLE;
            end
          end
          ST_PRIME: begin
            buf_wr <= 1'b1;
            step   <= step + 1'b1;
            state  <= ST_SET;
          end
          ST_RDY: begin
            if (sel_ready) state <= ST_PRIME2;
            else if (ready_hit) begin
              err   <= 1'b1;
              busy  <= 1'b0;
              state <= ST_IDLE;
            end
          end
          ST_PRIME2: begin
            buf_wr <= 1'b1;
            busy   <= 1'b0;
            state  <= ST_IDLE;
          end
          ST_CLR:  state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/aport_bringup_chk.sv
module aport_bringup_chk #(
  parameter int unsigned CTL_W   = 16,
  parameter bit          TX_PATH = 1'b1
)(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             stop,
  input logic [CTL_W-1:0] ctl_rd_data,
  input logic             ctl_wr_en,
  input logic [CTL_W-1:0] ctl_wr_data,
  input logic             buf_wr,
  input logic             stat_clr,
  input logic             fifo_en,
  input logic             busy,
  input logic             err
);
  localparam int unsigned LSB = TX_PATH ? 8 : 0;
  localparam logic [CTL_W-1:0] GMASK = CTL_W'(5'h1F) << LSB;

  logic [2:0]       wcnt;
  logic [CTL_W-1:0] last;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) begin
      wcnt <= '0;
      last <= '0;
    end else if (ctl_wr_en) begin
      wcnt <= wcnt + 1'b1;
      last <= ctl_wr_data;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !busy && !err && !fifo_en && !ctl_wr_en && !buf_wr && !stat_clr); // R1
  AST_GROUP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_en |-> (ctl_wr_data & ~GMASK) == '0); // R2
  AST_ONE_MORE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_en && busy |-> $countones(ctl_wr_data) == 32'(wcnt) + 1); // R2
  AST_CONFIRMED: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_en && busy && wcnt != 0 |-> (ctl_rd_data & last) == last); // R3
  AST_PRIME_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr && busy |-> wcnt == 3'd3); // R4
  AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start && !stop && !err)); // R8
  AST_STOP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !busy && !fifo_en && !err); // R9
  AST_STOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> ##1 (ctl_wr_en && ctl_wr_data == '0 && stat_clr)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err && !stop |=> err); // R10
endmodule

bind aport_bringup_seq aport_bringup_chk #(.CTL_W(CTL_W), .TX_PATH(TX_PATH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
  .ctl_rd_data(ctl_rd_data), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
  .buf_wr(buf_wr), .stat_clr(stat_clr), .fifo_en(fifo_en),
  .busy(busy), .err(err)
);

// File: tb/tb_aport_bringup_seq.sv
module tb_aport_bringup_seq;
  localparam int RMAX = 20;
  localparam int DMAX = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, stop = 1'b0, use_fifo = 1'b0;
  logic [3:0]  ser_is_tx = 4'b0, ser_ready = 4'b0;
  logic [15:0] stub_q;
  logic        ctl_wr_en, buf_wr, stat_clr, fifo_en, busy, err;
  logic [15:0] ctl_wr_data;

  always #4 clk = ~clk;  // 125 MHz

  aport_bringup_seq #(.CTL_W(16), .TX_PATH(1'b1), .NSER(4),
                      .RETRY_MAX(RMAX), .READY_MAX(DMAX)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .use_fifo(use_fifo),
    .ser_is_tx(ser_is_tx), .ser_ready(ser_ready), .ctl_rd_data(stub_q),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .buf_wr(buf_wr),
    .stat_clr(stat_clr), .fifo_en(fifo_en), .busy(busy), .err(err)
  );

  int errors = 0, checks = 0;

  // control register stub with programmable write latency and stuck bits
  int          stub_lat = 0;
  logic [15:0] stuck = 16'h0, pend = 16'h0;
  int          pcnt = 0;
  bit          pv = 1'b0;
  always @(posedge clk) begin
    if (!rst_n) begin
      stub_q <= 16'h0; pv <= 1'b0;
    end else if (ctl_wr_en) begin
      pend <= ctl_wr_data; pcnt <= stub_lat; pv <= 1'b1;
    end else if (pv) begin
      if (pcnt == 0) begin stub_q <= pend & ~stuck; pv <= 1'b0; end
      else pcnt <= pcnt - 1;
    end
  end

  // event log and ready driver
  int          cyc = 0, wn = 0, bn = 0, err_cyc = 0, rdy_cyc = 0;
  int          rdy_cnt = 0, rdy_delay = 0, sel = 0;
  logic [15:0] wr_log [8];
  int          wr_cyc [8];
  int          buf_cyc [4];
  int          buf_wn [4];
  bit          fifo_first = 1'b0, rdy_arm = 1'b0, sel_on = 1'b0;
  logic [3:0]  others = 4'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (ctl_wr_en && wn < 8) begin
        wr_log[wn] = ctl_wr_data; wr_cyc[wn] = cyc; wn++;
        if (wn == 1) fifo_first = fifo_en;
      end
      if (buf_wr && bn < 4) begin buf_cyc[bn] = cyc; buf_wn[bn] = wn; bn++; end
      if (err && err_cyc == 0) err_cyc = cyc;
    end
    if (rdy_arm && wn >= 5) begin
      if (rdy_cnt >= rdy_delay && !sel_on) begin sel_on = 1'b1; rdy_cyc = cyc; end
      rdy_cnt++;
    end
    ser_ready = others | (sel_on ? (4'b0001 << sel) : 4'b0000);
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ord_bit(input int j);
    case (j)
      0: ord_bit = 1;  1: ord_bit = 0;  2: ord_bit = 2;  3: ord_bit = 3;
      default: ord_bit = 4;
    endcase
  endfunction

  function automatic logic [15:0] exp_word(input int k);
    logic [15:0] w = 16'h0;
    for (int j = 0; j <= k; j++) w |= 16'h1 << (8 + ord_bit(j));
    return w;
  endfunction

  function automatic int first_tx(input logic [3:0] p);
    for (int i = 0; i < 4; i++) if (p[i]) return i;
    return 0;
  endfunction

  task automatic clear_log();
    wn = 0; bn = 0; err_cyc = 0; sel_on = 1'b0; rdy_cnt = 0;
  endtask

  task automatic pulse_start();
    start = 1'b1; @(negedge clk); #1; start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 3000 && busy; n++) begin @(negedge clk); #1; end
  endtask

  task automatic do_stop();
    stop = 1'b1; @(negedge clk); #1; stop = 1'b0;
    chk(!fifo_en && !ctl_wr_en, "R7 fifo off before clearing write", {fifo_en, ctl_wr_en}, 0);
    chk(!busy && !err, "R9 busy/err low after stop", {busy, err}, 0);
    @(negedge clk); #1;
    chk(ctl_wr_en && ctl_wr_data == 16'h0 && stat_clr, "R9 zero write with status clear",
        {ctl_wr_en, stat_clr, ctl_wr_data}, 32'h30000);
    repeat (6) @(negedge clk);
    #1;
  endtask

  task automatic run_seq(input bit uf, input logic [3:0] txp, input int lat, input int dly, input bit again);
    clear_log();
    stuck = 16'h0; stub_lat = lat; ser_is_tx = txp; use_fifo = uf;
    sel = first_tx(txp); others = ~(4'b0001 << sel); rdy_delay = dly; rdy_arm = 1'b1;
    pulse_start();
    chk(busy == 1'b1, "R8 busy after start", busy, 1);
    if (again) begin
      repeat (3) @(negedge clk);
      #1; pulse_start();
    end
    wait_idle();
    rdy_arm = 1'b0;
    chk(!err, "R5 no error on good run", err, 0);
    chk(wn == 5, "R8 five writes, repeated start ignored", wn, 5);
    for (int k = 0; k < 5 && k < wn; k++)
      chk(wr_log[k] == exp_word(k), "R2 release order", wr_log[k], exp_word(k));
    chk(bn == 2, "R4 two buffer primes", bn, 2);
    chk(buf_wn[0] == 3, "R4 prime after serializer clear", buf_wn[0], 3);
    chk(buf_wn[1] == 5 && buf_cyc[1] > rdy_cyc, "R5 prime after selected ready",
        buf_cyc[1], rdy_cyc + 1);
    chk(fifo_first == uf, "R7 fifo enable before first write", fifo_first, uf);
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (4) @(negedge clk);
    #1;
    chk(!busy && !err && !fifo_en && !ctl_wr_en && !buf_wr && !stat_clr, "R1 reset state",
        {busy, err, fifo_en, ctl_wr_en, buf_wr, stat_clr}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!busy && !ctl_wr_en, "R1 idle after reset", {busy, ctl_wr_en}, 0);

    // directed: serializer 2 selected, others ready early, repeated start
    run_seq(1'b1, 4'b0100, 0, 8, 1'b1);
    do_stop();
    // directed: no transmit serializer -> serializer 0
    run_seq(1'b0, 4'b0000, 2, 0, 1'b0);
    do_stop();

    for (int it = 0; it < 10; it++) begin
      run_seq(1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)),
              $urandom_range(0, 3), $urandom_range(0, 20), 1'($urandom_range(0, 1)));
      do_stop();
    end

    // retry timeout: serializer clear bit never appears
    clear_log(); stuck = 16'h0400; stub_lat = 0; ser_is_tx = 4'b0001; others = 4'b0;
    pulse_start();
    wait_idle();
    chk(err == 1'b1 && wn == 3, "R3 retry timeout halts", {err, 8'(wn)}, 32'h103);
    chk(err_cyc - wr_cyc[2] == RMAX, "R3 error after retry limit", err_cyc - wr_cyc[2], RMAX);
    chk(bn == 0, "R4 no prime after failed clear", bn, 0);
    repeat (5) @(negedge clk);
    #1;
    chk(stub_q == 16'h0300, "R3 released bits kept", stub_q, 16'h0300);
    pulse_start();
    repeat (5) @(negedge clk);
    #1;
    chk(wn == 3 && !busy, "R8 start ignored while error", {busy, 8'(wn)}, 3);
    chk(err == 1'b1, "R10 error sticky", err, 1);
    do_stop();
    stuck = 16'h0;

    // ready timeout: selected serializer never ready, others ready
    clear_log(); stub_lat = 1; ser_is_tx = 4'b0001; sel = 0; others = 4'b1110; rdy_arm = 1'b0;
    pulse_start();
    wait_idle();
    chk(err == 1'b1 && wn == 5, "R6 ready timeout error", {err, 8'(wn)}, 32'h105);
    chk(bn == 1, "R6 no second prime", bn, 1);
    chk(err_cyc - wr_cyc[4] >= DMAX && err_cyc - wr_cyc[4] <= DMAX + 8, "R6 timeout window",
        err_cyc - wr_cyc[4], DMAX);
    do_stop();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule